// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the software-facing side of an SMBus master. A byte-wide register bus reaches a small register file: a status byte, a control byte, a command byte, a slave-address byte, two data bytes and a 32-entry block buffer. Software loads the address, command and data, then writes the control register with the start bit set. The block decodes the protocol field and sends one request to a separate bit-level bus engine. The request carries the protocol, the direction, the 7-bit slave address, the command byte, up to 16 bits of write data and a block length.

The engine reads block-write bytes straight out of the buffer by index. During a block read it writes incoming bytes into the buffer. It ends each transfer with a one-cycle done pulse that can carry an error flag and the returned byte, word or block count. Software then reads the results back. The host reaches the buffer through one data register with a private index. Each access to that register advances the index, which wraps after 32 bytes. A write of the status register or a read of the control register rewinds it.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads zero, the status byte is zero and no request is issued.
- R2: Command (offset 0x03), address (0x04), data0 (0x05) and data1 (0x06) read back what was last written. Offsets not listed in R2, R3, R10 or R11 read 0x00.
- R3: Control is at offset 0x02. A read of control returns bits 4:0 of the last value written, with bits 7:5 zero, and rewinds the buffer index to 0.
- R4: A control write with bit 6 set, issued while idle with a supported protocol code in bits 4:2, raises `eng_req` for exactly one cycle, starting on the cycle after the write. Status bit 0 (busy) reads 1 from that cycle until the done pulse.
- R5: The supported protocol codes are 0 (quick), 1 (byte), 2 (byte with command), 3 (word with command) and 5 (block). A start with code 4, 6 or 7 sets status bit 2 and issues no request.
- R6: A start written while busy issues no request.
- R7: A done pulse while busy clears busy and sets status bit 1. If the error flag is high with it, status bit 2 is also set and the data registers are left unchanged.
- R8: On an error-free read, the returned data is stored by protocol. Codes 1 and 2 put `eng_rdata[7:0]` into data0. Code 3 puts `eng_rdata[7:0]` into data0 and `eng_rdata[15:8]` into data1. Code 5 puts the count from `eng_rdata[7:0]` into data0, and the engine fills the buffer by index.
- R9: The request reflects the registers at the moment of the start. The direction is address bit 0 (1 means read) and the slave address is address bits 7:1. Write data is {0,data0} for code 2 and {data1,data0} for code 3, and zero otherwise. The length is data0 for code 5 and zero otherwise. For a block write, the engine reads the buffer at any index through `eng_buf_idx`.
- R10: Each read or write of block data (offset 0x07) accesses the buffer at the host index and then advances the index, which wraps from 31 to 0.
- R11: Any write to status (offset 0x00) clears status bits 1 and 2 and rewinds the buffer index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, valid while selected) |
| eng_req | output | 1 | One-cycle transfer request |
| eng_proto | output | 3 | Protocol code |
| eng_rd | output | 1 | Direction, 1 read |
| eng_addr | output | 7 | Slave address |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Write payload |
| eng_len | output | 8 | Block length |
| eng_done | input | 1 | Transfer finished pulse |
| eng_err | input | 1 | Device error with done |
| eng_rdata | input | 16 | Returned byte, word or block count |
| eng_bwr | input | 1 | Engine writes a buffer byte |
| eng_bidx | input | 5 | Buffer index for the engine write |
| eng_bdata | input | 8 | Byte from the engine |
| eng_buf_idx | input | 5 | Buffer index the engine reads |
| eng_buf_byte | output | 8 | Buffer byte at `eng_buf_idx` |

## Verification
Every protocol code is started in both directions. This shows that the five supported codes each build their own payload and capture path, and that the three unsupported codes only raise the error bit. Each transfer is then repeated with the device error flag set, which separates the capture path from the status update. Randomized register contents keep the data0/data1 byte order from being confused. Buffer traffic of more than 32 bytes, mixed with status writes and control reads, shows the wrap and the two rewind paths. A second start issued while busy confirms that a launch is suppressed.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int unsigned OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_STAT = 6'h00;
    localparam logic [OFS_W-1:0] OFS_CTL  = 6'h02;
    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h03;
    localparam logic [OFS_W-1:0] OFS_ADR  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_D0   = 6'h05;
    localparam logic [OFS_W-1:0] OFS_D1   = 6'h06;
    localparam logic [OFS_W-1:0] OFS_BLK  = 6'h07;

    localparam int unsigned CTL_GO_BIT = 6;
    localparam int unsigned CTL_KEEP_W = 5;

    typedef enum logic [2:0] {
        PR_QUICK    = 3'd0,
        PR_BYTE     = 3'd1,
        PR_BYTE_CMD = 3'd2,
        PR_WORD_CMD = 3'd3,
        PR_BLOCK    = 3'd5
    } proto_e;

    typedef struct packed {
        logic [2:0]  proto;
        logic        rd;
        logic [6:0]  addr7;
        logic [7:0]  cmd;
        logic [15:0] wdata;
        logic [7:0]  len;
    } xfer_req_t;

    function automatic logic proto_ok(input logic [2:0] code);
        case (code)
            PR_QUICK, PR_BYTE, PR_BYTE_CMD, PR_WORD_CMD, PR_BLOCK: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic xfer_req_t build_req(input logic [2:0] code,
                                            input logic [7:0] adr,
                                            input logic [7:0] cmd,
                                            input logic [7:0] d0,
                                            input logic [7:0] d1);
        xfer_req_t r;
        r.proto = code;
        r.rd    = adr[0];
        r.addr7 = adr[7:1];
        r.cmd   = cmd;
        r.wdata = 16'h0000;
        r.len   = 8'h00;
        case (code)
            PR_BYTE_CMD: r.wdata = {8'h00, d0};
            PR_WORD_CMD: r.wdata = {d1, d0};
            PR_BLOCK:    r.len   = d0;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clr,
    input  logic             host_step,
    input  logic             host_we,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_byte,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_widx,
    input  logic [7:0]       eng_wdata,
    input  logic [IDX_W-1:0] eng_ridx,
    output logic [7:0]       eng_rbyte
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [7:0]       mem_q [DEPTH];
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (host_clr) begin
            idx_q <= '0;
        end else if (host_step) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            if (host_we) begin
                mem_q[idx_q] <= host_wdata;
            end
            if (eng_we) begin
                mem_q[eng_widx] <= eng_wdata;
            end
        end
    end

    assign host_byte = mem_q[idx_q];
    assign eng_rbyte = mem_q[eng_ridx];

    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (host_step && !host_clr && idx_q == LAST_IDX) |=> (idx_q == '0));

endmodule

// File: rtl/smbh_reqbuild.sv
module smbh_reqbuild
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] code,
    input  logic [7:0] adr,
    input  logic [7:0] cmd,
    input  logic [7:0] d0,
    input  logic [7:0] d1,
    output xfer_req_t  req_q
);

    xfer_req_t req_d;

    always_comb begin
        req_d = build_req(code, adr, cmd, d0, d1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (load) begin
            req_q <= req_d;
        end
    end

endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch_try,
    input  logic [2:0] code,
    input  logic       stat_clr,
    input  logic       eng_done,
    input  logic       eng_err,
    output logic       busy_q,
    output logic       done_q,
    output logic       err_q,
    output logic       req_q,
    output logic       load,
    output logic       capture
);

    logic accept;

    assign accept  = launch_try && !busy_q;
    assign load    = accept && proto_ok(code);
    assign capture = busy_q && eng_done && !eng_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (stat_clr) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (accept) begin
                if (proto_ok(code)) begin
                    busy_q <= 1'b1;
                    req_q  <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (busy_q && eng_done) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                if (eng_err) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    a_r4_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        req_q |-> busy_q);

    a_r6_no_req_after_busy: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !req_q);

    a_r5_bad_code_flags: assert property (@(posedge clk) disable iff (rst)
        (launch_try && !busy_q && !proto_ok(code)) |=> (err_q && !req_q));

    a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (busy_q && eng_done) |=> (done_q && !busy_q));

    a_r11_clear_flags: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !(busy_q && eng_done) && !launch_try) |=> (!done_q && !err_q));

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smbh_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [5:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             eng_req,
    output logic [2:0]       eng_proto,
    output logic             eng_rd,
    output logic [6:0]       eng_addr,
    output logic [7:0]       eng_cmd,
    output logic [15:0]      eng_wdata,
    output logic [7:0]       eng_len,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic [15:0]      eng_rdata,
    input  logic             eng_bwr,
    input  logic [IDX_W-1:0] eng_bidx,
    input  logic [7:0]       eng_bdata,
    input  logic [IDX_W-1:0] eng_buf_idx,
    output logic [7:0]       eng_buf_byte
);

    logic host_wr, host_rd;
    logic [CTL_KEEP_W-1:0] ctl_q;
    logic [7:0] cmd_q, adr_q, d0_q, d1_q;
    logic busy_q, done_q, err_q, req_q, load, capture;
    logic launch_try, stat_clr, idx_clr, blk_step;
    logic [7:0] blk_byte;
    xfer_req_t req_cur;

    assign host_wr = bus_sel && bus_wr;
    assign host_rd = bus_sel && !bus_wr;

    assign launch_try = host_wr && (bus_addr == OFS_CTL) && bus_wdata[CTL_GO_BIT];
    assign stat_clr   = host_wr && (bus_addr == OFS_STAT);
    assign idx_clr    = stat_clr || (host_rd && (bus_addr == OFS_CTL));
    assign blk_step   = bus_sel && (bus_addr == OFS_BLK);

    smbh_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch_try (launch_try),
        .code       (bus_wdata[4:2]),
        .stat_clr   (stat_clr),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .busy_q     (busy_q),
        .done_q     (done_q),
        .err_q      (err_q),
        .req_q      (req_q),
        .load       (load),
        .capture    (capture)
    );

    smbh_reqbuild u_req (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .code  (bus_wdata[4:2]),
        .adr   (adr_q),
        .cmd   (cmd_q),
        .d0    (d0_q),
        .d1    (d1_q),
        .req_q (req_cur)
    );

    smbh_blkbuf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_clr   (idx_clr),
        .host_step  (blk_step),
        .host_we    (host_wr && (bus_addr == OFS_BLK)),
        .host_wdata (bus_wdata),
        .host_byte  (blk_byte),
        .eng_we     (eng_bwr),
        .eng_widx   (eng_bidx),
        .eng_wdata  (eng_bdata),
        .eng_ridx   (eng_buf_idx),
        .eng_rbyte  (eng_buf_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmd_q <= 8'h00;
            adr_q <= 8'h00;
            d0_q  <= 8'h00;
            d1_q  <= 8'h00;
        end else begin
            if (host_wr) begin
                case (bus_addr)
                    OFS_CTL: ctl_q <= bus_wdata[CTL_KEEP_W-1:0];
                    OFS_CMD: cmd_q <= bus_wdata;
                    OFS_ADR: adr_q <= bus_wdata;
                    OFS_D0:  d0_q  <= bus_wdata;
                    OFS_D1:  d1_q  <= bus_wdata;
                    default: ;
                endcase
            end
            if (capture && req_cur.rd) begin
                case (req_cur.proto)
                    PR_BYTE, PR_BYTE_CMD, PR_BLOCK: d0_q <= eng_rdata[7:0];
                    PR_WORD_CMD: begin
                        d0_q <= eng_rdata[7:0];
                        d1_q <= eng_rdata[15:8];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_STAT: bus_rdata = {5'b0, err_q, done_q, busy_q};
            OFS_CTL:  bus_rdata = {{(8-CTL_KEEP_W){1'b0}}, ctl_q};
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_ADR:  bus_rdata = adr_q;
            OFS_D0:   bus_rdata = d0_q;
            OFS_D1:   bus_rdata = d1_q;
            OFS_BLK:  bus_rdata = blk_byte;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign eng_req   = req_q;
    assign eng_proto = req_cur.proto;
    assign eng_rd    = req_cur.rd;
    assign eng_addr  = req_cur.addr7;
    assign eng_cmd   = req_cur.cmd;
    assign eng_wdata = req_cur.wdata;
    assign eng_len   = req_cur.len;

    a_r7_err_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (busy_q && eng_done && eng_err && !host_wr) |=> ($stable(d0_q) && $stable(d1_q)));

endmodule

// File: tb/test_smb_host_regs.sv
`timescale 1ns/1ps
module test_smb_host_regs;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic eng_req, eng_rd;
    logic [2:0] eng_proto;
    logic [6:0] eng_addr;
    logic [7:0] eng_cmd, eng_len, eng_buf_byte;
    logic [15:0] eng_wdata;
    logic eng_done = 0, eng_err = 0, eng_bwr = 0;
    logic [15:0] eng_rdata = 0;
    logic [4:0] eng_bidx = 0, eng_buf_idx = 0;
    logic [7:0] eng_bdata = 0;

    int total = 0;
    int bad = 0;

    logic [4:0] m_ctl;
    logic [7:0] m_cmd, m_adr, m_d0, m_d1;
    logic [7:0] m_buf [32];
    int m_idx;
    bit m_busy, m_done, m_err;

    always #2.5 clk = ~clk;

    smb_host_regs i_smb_host_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_req(eng_req), .eng_proto(eng_proto), .eng_rd(eng_rd),
        .eng_addr(eng_addr), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
        .eng_len(eng_len), .eng_done(eng_done), .eng_err(eng_err),
        .eng_rdata(eng_rdata), .eng_bwr(eng_bwr), .eng_bidx(eng_bidx),
        .eng_bdata(eng_bdata), .eng_buf_idx(eng_buf_idx),
        .eng_buf_byte(eng_buf_byte)
    );

    function automatic bit exp_ok(input logic [2:0] p);
        return (p == 3'd0 || p == 3'd1 || p == 3'd2 || p == 3'd3 || p == 3'd5);
    endfunction

    function automatic logic [15:0] exp_wdata(input logic [2:0] p);
        if (p == 3'd2) return {8'h00, m_d0};
        if (p == 3'd3) return {m_d1, m_d0};
        return 16'h0000;
    endfunction

    function automatic logic [7:0] exp_status();
        return {5'b0, m_err, m_done, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic m_write(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'h00: begin m_done = 0; m_err = 0; m_idx = 0; end
            6'h02: begin
                m_ctl = d[4:0];
                if (d[6] && !m_busy) begin
                    if (exp_ok(d[4:2])) m_busy = 1; else m_err = 1;
                end
            end
            6'h03: m_cmd = d;
            6'h04: m_adr = d;
            6'h05: m_d0 = d;
            6'h06: m_d1 = d;
            6'h07: begin m_buf[m_idx] = d; m_idx = (m_idx + 1) % 32; end
            default: ;
        endcase
        bus_write(a, d);
    endtask

    task automatic m_read(input logic [5:0] a, input string tag);
        logic [7:0] e, got;
        case (a)
            6'h00: e = exp_status();
            6'h02: e = {3'b0, m_ctl};
            6'h03: e = m_cmd;
            6'h04: e = m_adr;
            6'h05: e = m_d0;
            6'h06: e = m_d1;
            6'h07: e = m_buf[m_idx];
            default: e = 8'h00;
        endcase
        bus_read(a, got);
        chk(tag, {24'h0, got}, {24'h0, e});
        if (a == 6'h02) m_idx = 0;
        if (a == 6'h07) m_idx = (m_idx + 1) % 32;
    endtask

    task automatic do_txn(input logic [2:0] p, input bit rdb, input bit errb);
        logic [7:0] ctlv;
        logic [15:0] rd_val;
        int n, lim;
        m_write(6'h04, {7'($urandom), rdb});
        m_write(6'h03, 8'($urandom));
        if (p == 3'd5 && !rdb) m_write(6'h05, 8'($urandom % 41));
        else m_write(6'h05, 8'($urandom));
        m_write(6'h06, 8'($urandom));
        ctlv = {1'b0, 1'b1, 1'b0, p, 2'($urandom)};
        m_write(6'h02, ctlv);
        if (!exp_ok(p)) begin
            chk("R5 no request for bad code", {31'h0, eng_req}, 32'h0);
            m_read(6'h00, "R5 error bit on bad code");
            m_write(6'h00, 8'h00);
            return;
        end
        chk("R4 request pulse", {31'h0, eng_req}, 32'h1);
        chk("R4 protocol", {29'h0, eng_proto}, {29'h0, p});
        chk("R9 direction", {31'h0, eng_rd}, {31'h0, rdb});
        chk("R9 slave address", {25'h0, eng_addr}, {25'h0, m_adr[7:1]});
        chk("R9 command", {24'h0, eng_cmd}, {24'h0, m_cmd});
        chk("R9 write data", {16'h0, eng_wdata}, {16'h0, exp_wdata(p)});
        chk("R9 length", {24'h0, eng_len}, {24'h0, (p == 3'd5) ? m_d0 : 8'h00});
        m_read(6'h00, "R4 busy status");
        m_write(6'h02, ctlv);
        chk("R6 start ignored while busy", {31'h0, eng_req}, 32'h0);
        if (p == 3'd5 && !rdb) begin
            lim = (m_d0 > 32) ? 32 : int'(m_d0);
            for (int i = 0; i < lim; i++) begin
                @(negedge clk);
                eng_buf_idx = 5'(i);
                #1 chk("R9 block write byte", {24'h0, eng_buf_byte}, {24'h0, m_buf[i]});
            end
        end
        n = 1 + ($urandom % 32);
        if (p == 3'd5 && rdb) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                eng_bwr = 1; eng_bidx = 5'(i); eng_bdata = 8'($urandom);
                m_buf[i] = eng_bdata;
                @(posedge clk); #1;
                eng_bwr = 0;
            end
        end
        rd_val = (p == 3'd5) ? {8'($urandom), 8'(n)} : 16'($urandom);
        @(negedge clk);
        eng_done = 1; eng_err = errb; eng_rdata = rd_val;
        @(posedge clk); #1;
        eng_done = 0; eng_err = 0;
        m_busy = 0; m_done = 1;
        if (errb) m_err = 1;
        else if (rdb) begin
            if (p == 3'd1 || p == 3'd2 || p == 3'd5) m_d0 = rd_val[7:0];
            if (p == 3'd3) begin m_d0 = rd_val[7:0]; m_d1 = rd_val[15:8]; end
        end
        m_read(6'h00, "R7 done status");
        m_read(6'h05, "R8 data0 after transfer");
        m_read(6'h06, "R8 data1 after transfer");
        if (p == 3'd5 && rdb && !errb) begin
            m_read(6'h02, "R3 control read rewinds");
            for (int i = 0; i < n; i++) m_read(6'h07, "R8 block read byte");
        end
        m_write(6'h00, 8'h00);
        m_read(6'h00, "R11 status cleared");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        m_ctl = 0; m_cmd = 0; m_adr = 0; m_d0 = 0; m_d1 = 0;
        m_idx = 0; m_busy = 0; m_done = 0; m_err = 0;
        for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 no request after reset", {31'h0, eng_req}, 32'h0);
        m_read(6'h00, "R1 status after reset");
        m_read(6'h02, "R1 control after reset");
        m_read(6'h03, "R1 command after reset");
        m_read(6'h05, "R1 data0 after reset");
        m_read(6'h07, "R1 buffer after reset");

        // R2 plain registers and unmapped offsets
        for (int i = 0; i < 16; i++) begin
            v = 8'($urandom);
            m_write(6'h03 + 6'(i % 4), v);
            m_read(6'h03 + 6'(i % 4), "R2 readback");
        end
        m_read(6'h01, "R2 unmapped offset");
        m_read(6'h08, "R2 unmapped offset");
        m_read(6'h3f, "R2 unmapped offset");

        // R3 control readback without start
        for (int i = 0; i < 6; i++) begin
            m_write(6'h02, 8'($urandom) & 8'hbf);
            m_read(6'h02, "R3 control low bits");
            chk("R3 no request without start", {31'h0, eng_req}, 32'h0);
        end

        // R10 wrap, R11 and R3 index rewinds
        m_write(6'h00, 8'h00);
        for (int i = 0; i < 37; i++) m_write(6'h07, 8'($urandom));
        m_read(6'h02, "R3 rewind before scan");
        for (int i = 0; i < 34; i++) m_read(6'h07, "R10 buffer scan with wrap");
        m_write(6'h00, 8'hff);
        m_read(6'h07, "R11 status write rewinds index");
        m_read(6'h07, "R10 next entry");

        // every code both directions, with and without device error
        for (int e = 0; e < 2; e++)
            for (int p = 0; p < 8; p++)
                for (int r = 0; r < 2; r++)
                    do_txn(3'(p), r[0], e[0]);

        // random mix
        for (int k = 0; k < 30; k++) begin
            do_txn(3'($urandom), 1'($urandom), ($urandom % 4) == 0);
            if (($urandom % 3) == 0) begin
                m_write(6'h07, 8'($urandom));
                m_read(6'h07, "R10 random buffer access");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule